// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Acknowledge Controller

This block decides when a small processor core accepts an interrupt. Hardware request lines and a nonmaskable request are captured as pending flags. Software interrupt and trap commands arrive as single-cycle commands with a number. Each cycle the block picks at most one source. A software command comes first, then a pending nonmaskable request, then the lowest-numbered pending maskable line. A maskable line is eligible only when its bit in a 16-bit mask register is set and a global disable bit is clear.

On acceptance the block raises a one-cycle acknowledge pulse that carries the interrupt number and its vector address. Vectors sit two words apart, so each slot holds a two-word branch. The acknowledged flag is cleared. The global disable bit is set on every acceptance except a trap. Software can also set or clear the disable bit directly. The mask register is written through a memory-mapped write port.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After a synchronous reset, `mode_bit` is 1, `irq_mask` is 0 and `ack_valid` is 0.
- R2: A write with `reg_wr_en` high and `reg_wr_addr` equal to 0x0004 loads `reg_wr_data` into `irq_mask` at the next edge. A write to any other address leaves `irq_mask` unchanged.
- R3: Maskable line k (number k, from 1 to NUM_IRQ, carried on `irq_req[k-1]`) is enabled by one mask bit. Line 1 uses bit 0. Lines 2 and 3 share bit 1. Line k≥4 uses bit k-2.
- R4: A pulse on `irq_req` sets a pending flag that persists while the line is masked or `mode_bit` is 1. The line is acknowledged once it is eligible, and its flag is cleared when it is acknowledged.
- R5: When several eligible maskable lines are pending, the lowest number is acknowledged first.
- R6: A maskable line is accepted only while `mode_bit` is 0. Every acknowledge except a trap leaves `mode_bit` at 1.
- R7: `mode_set` forces `mode_bit` to 1 and `mode_clr` forces it to 0. If both are high, set wins. The automatic set on an acknowledge overrides `mode_clr`. Changing `mode_bit` never alters `irq_mask`.
- R8: A pulse on `nmi_req` is latched and acknowledged as number 18 regardless of `mode_bit` and the mask. It ranks above every maskable line.
- R9: A software command (`sw_valid`) is acknowledged in the cycle that follows, regardless of `mode_bit`. It takes precedence over NMI and maskable requests, which stay pending. When `sw_trap` is 1 the command is a trap with number 17 and does not set `mode_bit`. Otherwise its number is `sw_num` and it sets `mode_bit`.
- R10: `ack_valid` is a registered one-cycle pulse per acceptance, with `ack_vec` = VEC_BASE + 2*`ack_num` (VEC_BASE is 0 by default). A request latched at edge N is acknowledged at edge N+1 at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_IRQ | Maskable request pulses, bit k-1 is line k |
| nmi_req | input | 1 | Nonmaskable request pulse |
| sw_valid | input | 1 | Software interrupt or trap command |
| sw_trap | input | 1 | Command is a trap |
| sw_num | input | NUM_W | Number for a software interrupt |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write address |
| reg_wr_data | input | MASK_W | Register write data |
| mode_set | input | 1 | Force global disable to 1 |
| mode_clr | input | 1 | Force global disable to 0 |
| ack_valid | output | 1 | Acknowledge pulse |
| ack_num | output | NUM_W | Acknowledged interrupt number |
| ack_vec | output | ADDR_W | Vector address of the acknowledged interrupt |
| mode_bit | output | 1 | Global disable bit |
| irq_mask | output | MASK_W | Mask register contents |

## Verification
The hardest situation to reach is a hardware request that is pending and eligible in the same cycle as a software command. The command must win, and the hardware flag must survive and be acknowledged later. The directed stimulus gets there in steps. It latches line 1 while `mode_bit` is 1, clears the disable bit, and issues a software interrupt in the exact cycle the line becomes eligible. It then clears the disable bit again to confirm that line 1 is still pending. Random traffic with frequent disable-bit clears covers further collisions among NMI, traps and the shared mask bit. That traffic is checked every cycle against a bench model.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_NMI  = 2'd2,
    SRC_HW   = 2'd3
  } ack_src_e;

  function automatic int mask_bit_of(input int line_idx);
    if (line_idx == 0) return 0;
    if (line_idx <= 2) return 1;
    return line_idx - 1;
  endfunction
endpackage

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  always_ff @(posedge clk) begin
    if (rst) flag_o <= '0;
    else     flag_o <= (flag_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] below;
  assign below[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]    = req_i[i] & ~below[i];
    assign below[i+1]  = below[i] | req_i[i];
  end

  assign any_o = below[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int NUM_IRQ   = 6,
  parameter int MASK_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int NUM_W     = 5,
  parameter int MASK_ADDR = 4,
  parameter int VEC_BASE  = 0,
  parameter int TRAP_NUM  = 17,
  parameter int NMI_NUM   = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               nmi_req,
  input  logic               sw_valid,
  input  logic               sw_trap,
  input  logic [NUM_W-1:0]   sw_num,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_wr_addr,
  input  logic [MASK_W-1:0]  reg_wr_data,
  input  logic               mode_set,
  input  logic               mode_clr,
  output logic               ack_valid,
  output logic [NUM_W-1:0]   ack_num,
  output logic [ADDR_W-1:0]  ack_vec,
  output logic               mode_bit,
  output logic [MASK_W-1:0]  irq_mask
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] pend_q, line_en, elig, gnt_hw, clr_hw;
  logic               nmi_q, nmi_clr;
  logic               hw_any;
  logic [IDX_W-1:0]   hw_idx;
  ack_src_e           src;
  logic [NUM_W-1:0]   sel_num;
  logic               take, auto_set;

  irq_pend_flags #(.W(NUM_IRQ)) u_hw_flags (
    .clk(clk), .rst(rst), .set_i(irq_req), .clr_i(clr_hw), .flag_o(pend_q)
  );

  irq_pend_flags #(.W(1)) u_nmi_flag (
    .clk(clk), .rst(rst), .set_i(nmi_req), .clr_i(nmi_clr), .flag_o(nmi_q)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line_en
    localparam int MB = mask_bit_of(i);
    assign line_en[i] = irq_mask[MB];
  end

  assign elig = pend_q & line_en & {NUM_IRQ{~mode_bit}};

  irq_prio_pick #(.N(NUM_IRQ)) u_pick (
    .req_i(elig), .gnt_o(gnt_hw), .any_o(hw_any), .idx_o(hw_idx)
  );

  always_comb begin
    src     = SRC_NONE;
    sel_num = '0;
    if (sw_valid) begin
      src     = SRC_SW;
      sel_num = sw_trap ? NUM_W'(TRAP_NUM) : sw_num;
    end else if (nmi_q) begin
      src     = SRC_NMI;
      sel_num = NUM_W'(NMI_NUM);
    end else if (hw_any) begin
      src     = SRC_HW;
      sel_num = NUM_W'(hw_idx) + NUM_W'(1);
    end
  end

  assign take     = (src != SRC_NONE);
  assign auto_set = take && !((src == SRC_SW) && sw_trap);
  assign clr_hw   = (src == SRC_HW) ? gnt_hw : '0;
  assign nmi_clr  = (src == SRC_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_bit  <= 1'b1;
      irq_mask  <= '0;
      ack_valid <= 1'b0;
      ack_num   <= '0;
      ack_vec   <= '0;
    end else begin
      if (auto_set || mode_set) mode_bit <= 1'b1;
      else if (mode_clr)        mode_bit <= 1'b0;
      if (reg_wr_en && (reg_wr_addr == ADDR_W'(MASK_ADDR)))
        irq_mask <= reg_wr_data;
      ack_valid <= take;
      if (take) begin
        ack_num <= sel_num;
        ack_vec <= ADDR_W'(VEC_BASE + 2 * int'(sel_num));
      end
    end
  end
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk #(
  parameter int MASK_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int NUM_W     = 5,
  parameter int MASK_ADDR = 4,
  parameter int TRAP_NUM  = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic              mode_set,
  input logic              mode_clr,
  input logic              ack_valid,
  input logic [NUM_W-1:0]  ack_num,
  input logic              mode_bit,
  input logic [MASK_W-1:0] irq_mask
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_bit && irq_mask == '0 && !ack_valid));

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_wr_addr == ADDR_W'(MASK_ADDR)) |=> $stable(irq_mask));

  assert_ack_sets_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_num != NUM_W'(TRAP_NUM)) |-> mode_bit);

  assert_set_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    mode_set |=> mode_bit);

  assert_clr_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_clr && !mode_set) |=> (!mode_bit || ack_valid));
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(
  .MASK_W(MASK_W), .ADDR_W(ADDR_W), .NUM_W(NUM_W),
  .MASK_ADDR(MASK_ADDR), .TRAP_NUM(TRAP_NUM)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
  .mode_set(mode_set), .mode_clr(mode_clr), .ack_valid(ack_valid),
  .ack_num(ack_num), .mode_bit(mode_bit), .irq_mask(irq_mask)
);

// File: tb/irq_ack_ctrl_tb.sv
module irq_ack_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 6;
  localparam int NW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] irq_req = '0;
  logic          nmi_req = 1'b0, sw_valid = 1'b0, sw_trap = 1'b0;
  logic [NW-1:0] sw_num = '0;
  logic          reg_wr_en = 1'b0;
  logic [15:0]   reg_wr_addr = '0, reg_wr_data = '0;
  logic          mode_set = 1'b0, mode_clr = 1'b0;
  logic          ack_valid, mode_bit;
  logic [NW-1:0] ack_num;
  logic [15:0]   ack_vec, irq_mask;

  int checks = 0;
  int errors = 0;

  logic          m_mode, e_valid, m_nmi;
  logic [15:0]   m_mask, e_vec;
  logic [NI-1:0] m_pend;
  logic [NW-1:0] e_num;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ack_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_req(nmi_req),
    .sw_valid(sw_valid), .sw_trap(sw_trap), .sw_num(sw_num),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .mode_set(mode_set), .mode_clr(mode_clr), .ack_valid(ack_valid),
    .ack_num(ack_num), .ack_vec(ack_vec), .mode_bit(mode_bit), .irq_mask(irq_mask)
  );

  function automatic int mbit(input int idx);
    return (idx == 0) ? 0 : ((idx <= 2) ? 1 : idx - 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic set_auto;
    logic [NI-1:0] clrp;
    logic nmi_take;
    logic found;
    set_auto = 1'b0; clrp = '0; nmi_take = 1'b0; found = 1'b0;
    if (rst) begin
      m_mode = 1'b1; m_mask = '0; m_pend = '0; m_nmi = 1'b0;
      e_valid = 1'b0;
      return;
    end
    e_valid = 1'b0;
    if (sw_valid) begin
      e_valid = 1'b1; e_num = sw_trap ? NW'(17) : sw_num; set_auto = !sw_trap;
    end else if (m_nmi) begin
      e_valid = 1'b1; e_num = NW'(18); set_auto = 1'b1; nmi_take = 1'b1;
    end else if (!m_mode) begin
      for (int i = 0; i < NI; i++) begin
        if (!found && m_pend[i] && m_mask[mbit(i)]) begin
          found = 1'b1; clrp[i] = 1'b1; e_valid = 1'b1;
          e_num = NW'(i + 1); set_auto = 1'b1;
        end
      end
    end
    if (e_valid) e_vec = 16'(2 * int'(e_num));
    if (set_auto || mode_set) m_mode = 1'b1;
    else if (mode_clr)        m_mode = 1'b0;
    if (reg_wr_en && reg_wr_addr == 16'h0004) m_mask = reg_wr_data;
    m_pend = (m_pend & ~clrp) | irq_req;
    m_nmi  = (m_nmi & ~nmi_take) | nmi_req;
  endtask

  task automatic step(input string tag);
    model_update();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " ack_valid"}, int'(ack_valid), int'(e_valid));
    if (e_valid) begin
      chk({tag, " ack_num"}, int'(ack_num), int'(e_num));
      chk({tag, " ack_vec"}, int'(ack_vec), int'(e_vec));
    end
    chk({tag, " mode_bit"}, int'(mode_bit), int'(m_mode));
    chk({tag, " irq_mask"}, int'(irq_mask), int'(m_mask));
  endtask

  task automatic idle();
    irq_req = '0; nmi_req = 0; sw_valid = 0; sw_trap = 0; sw_num = '0;
    reg_wr_en = 0; mode_set = 0; mode_clr = 0;
  endtask

  task automatic wr(input logic [15:0] addr, input logic [15:0] data);
    reg_wr_en = 1; reg_wr_addr = addr; reg_wr_data = data;
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1234_5678);
    @(negedge clk);
    rst = 1; step("R1 reset"); step("R1 reset");
    rst = 0;
    chk("R1 mode after reset", int'(mode_bit), 1);
    chk("R1 mask after reset", int'(irq_mask), 0);
    chk("R1 no ack after reset", int'(ack_valid), 0);

    // R2: wrong address ignored, right address loads
    wr(16'h0005, 16'hFFFF); step("R2 wrong addr"); idle();
    chk("R2 wrong addr mask", int'(irq_mask), 0);
    wr(16'h0004, 16'h0002); step("R2 write"); idle();
    chk("R2 mask loaded", int'(irq_mask), 2);

    // R3/R4: INT3 latched while disabled, served via shared bit 1
    irq_req = 6'b000100; step("R4 latch"); idle();
    chk("R4 no ack while disabled", int'(ack_valid), 0);
    mode_clr = 1; step("R7 clr"); idle();
    chk("R7 mode cleared", int'(mode_bit), 0);
    step("R3 ack");
    chk("R3 INT3 via shared bit", int'(ack_num), 3);
    chk("R10 vector of 3", int'(ack_vec), 6);
    chk("R6 mode set by ack", int'(mode_bit), 1);
    mode_clr = 1; mode_set = 1; step("R7 both"); idle();
    chk("R7 set wins", int'(mode_bit), 1);
    chk("R7 mask untouched", int'(irq_mask), 2);

    // R5: priority
    wr(16'h0004, 16'hFFFF); irq_req = 6'b010010; step("R5 latch"); idle();
    mode_clr = 1; step("R5 clr"); idle();
    step("R5 first");
    chk("R5 lowest first", int'(ack_num), 2);
    mode_clr = 1; step("R5 clr2"); idle();
    step("R5 second");
    chk("R5 next served", int'(ack_num), 5);

    // R9: trap leaves mode clear
    mode_clr = 1; step("R9 clr"); idle();
    sw_valid = 1; sw_trap = 1; step("R9 trap"); idle();
    chk("R9 trap number", int'(ack_num), 17);
    chk("R9 trap keeps mode", int'(mode_bit), 0);

    // R8: NMI while disabled
    mode_set = 1; nmi_req = 1; step("R8 latch"); idle();
    step("R8 ack");
    chk("R8 nmi number", int'(ack_num), 18);
    chk("R10 nmi vector", int'(ack_vec), 36);

    // R9: software wins over eligible hardware, which stays pending
    irq_req = 6'b000001; step("R9 latch"); idle();
    mode_clr = 1; step("R9 clr"); idle();
    sw_valid = 1; sw_num = 5'd9; step("R9 sw wins"); idle();
    chk("R9 sw number", int'(ack_num), 9);
    mode_clr = 1; step("R9 clr again"); idle();
    step("R9 hw later");
    chk("R9 hw stayed pending", int'(ack_num), 1);
    step("R10 pulse ends");
    chk("R10 one-cycle pulse", int'(ack_valid), 0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < NI; b++) irq_req[b] = ($urandom % 10) == 0;
      nmi_req  = ($urandom % 40) == 0;
      sw_valid = ($urandom % 16) == 0;
      sw_trap  = ($urandom % 2) == 0;
      sw_num   = NW'($urandom % 17);
      mode_set = ($urandom % 20) == 0;
      mode_clr = ($urandom % 3) == 0;
      reg_wr_en   = ($urandom % 12) == 0;
      reg_wr_addr = (($urandom % 2) == 0) ? 16'h0004 : 16'($urandom);
      reg_wr_data = 16'($urandom);
      step("R4 R5 R6 R8 R9 random");
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule